// File: doc/BRIEF.md
# Switching-Limited Dual-Edge Pseudorandom Word Generator

This block produces a parallel pseudorandom word for driving a wide link, such as a training or scrambling pattern across many wires. A Fibonacci linear feedback shift register of N bits moves one step on every rising and on every falling edge of `clk`, so the pattern rate is twice the clock rate.

Each new register value is compared with the word currently driven on the output pins, and the bits that differ are counted. If more than LIMIT bits would change, the complement of the new value is driven instead. This bounds how many output pins switch at once. The register keeps its true value either way, so the sequence itself is not changed by the inversion.

The block has two phases. While the active-low asynchronous reset is low it holds the seed. After release it enters the run phase, in which every clock edge makes one step. Asserting reset again from the run phase returns it to the seed phase at once.

Top module: `sw_limited_lfsr`

## Requirements
- R1: While `reset_n` is low, `word_out` equals the seed 0x0001 with no clock edge needed. After release it stays 0x0001, not inverted, until the first clock edge.
- R2: The generator makes exactly one step on each rising edge and one step on each falling edge of `clk`.
- R3: One step shifts the register left by one bit and fills bit 0 with the XOR of the bits selected by TAP_MASK. The default mask 0xB400 selects bits 15, 13, 12 and 10.
- R4: With the defaults the register never holds zero. It first returns to 0x0001 after exactly 65535 steps.
- R5: If the new register value differs from the word driven before the step in more than LIMIT (default 7) bit positions, `word_out` becomes the bitwise complement of the new register value.
- R6: If it differs in LIMIT or fewer positions, `word_out` becomes the new register value unchanged.
- R7: From one step to the next, at most max(LIMIT, N-LIMIT-1) output bits change. This is 8 with the defaults.
- R8: Asserting `reset_n` in the middle of a run returns `word_out` to the seed immediately. After release the sequence starts again from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; both edges are active |
| reset_n | input | 1 | Asynchronous active-low reset to the seed |
| word_out | output | N | Pattern word, true or complemented |

## Verification
The bench runs the whole default period of 65535 steps, so every register value is met once. At every half cycle it compares `word_out` with an arithmetic model of the shift, the tap XOR and the count-and-complement rule. Steps that take the complement and steps that pass the value through are both counted, so a wrong threshold or a comparison against the wrong previous word shows up as a mismatch. The bench also counts how many output bits change on each step and checks the bound.

A reset is applied in the middle of the run at a time away from any clock edge. The bench confirms the seed appears without a clock and that the sequence then restarts from its first step. Together these show apart an error in the feedback, an edge that is missed, and an error in the inversion decision.

// File: rtl/sw_limited_lfsr_pkg.sv
`timescale 1ns/1ps
package sw_limited_lfsr_pkg;
    localparam int unsigned SLL_DEF_WIDTH = 16;
    localparam int unsigned SLL_DEF_LIMIT = 7;

    typedef enum logic {
        PICK_TRUE   = 1'b0,
        PICK_INVERT = 1'b1
    } sll_pick_e;
endpackage

// File: rtl/sll_step.sv
`timescale 1ns/1ps
module sll_step #(
    parameter int unsigned N = 16,
    parameter logic [N-1:0] TAP_MASK = 16'hB400
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);
    logic fb;

    assign fb  = ^(cur & TAP_MASK);
    assign nxt = {cur[N-2:0], fb};
endmodule

// File: rtl/sll_limiter.sv
`timescale 1ns/1ps
module sll_limiter
    import sw_limited_lfsr_pkg::*;
#(
    parameter int unsigned N     = 16,
    parameter int unsigned LIMIT = 7
) (
    input  logic [N-1:0] cand,
    input  logic [N-1:0] prev,
    output logic [N-1:0] word
);
    localparam int unsigned CW = $clog2(N + 1);

    logic [N-1:0]  diff;
    logic [CW-1:0] cnt;
    sll_pick_e     pick;

    assign diff = cand ^ prev;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(N); i++) begin
            cnt = cnt + CW'(diff[i]);
        end
    end

    assign pick = (32'(cnt) > LIMIT) ? PICK_INVERT : PICK_TRUE;

    always_comb begin
        unique case (pick)
            PICK_TRUE:   word = cand;
            PICK_INVERT: word = ~cand;
            default:     word = cand;
        endcase
    end
endmodule

// File: rtl/sll_dual_edge_reg.sv
`timescale 1ns/1ps
module sll_dual_edge_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         reset_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] half_p;
    logic [W-1:0] half_n;

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) begin
            half_p <= INIT;
        end else begin
            half_p <= d ^ half_n;
        end
    end

    always_ff @(negedge clk or negedge reset_n) begin
        if (!reset_n) begin
            half_n <= '0;
        end else begin
            half_n <= d ^ half_p;
        end
    end

    assign q = half_p ^ half_n;
endmodule

// File: rtl/sw_limited_lfsr.sv
`timescale 1ns/1ps
module sw_limited_lfsr
    import sw_limited_lfsr_pkg::*;
#(
    parameter int unsigned N        = SLL_DEF_WIDTH,
    parameter logic [N-1:0] TAP_MASK = 16'hB400,
    parameter logic [N-1:0] SEED     = 16'h0001,
    parameter int unsigned LIMIT    = SLL_DEF_LIMIT
) (
    input  logic         clk,
    input  logic         reset_n,
    output logic [N-1:0] word_out
);
    logic [N-1:0] state_q;
    logic [N-1:0] state_d;
    logic [N-1:0] out_d;

    sll_step #(.N(N), .TAP_MASK(TAP_MASK)) u_step (
        .cur (state_q),
        .nxt (state_d)
    );

    sll_limiter #(.N(N), .LIMIT(LIMIT)) u_lim (
        .cand (state_d),
        .prev (word_out),
        .word (out_d)
    );

    sll_dual_edge_reg #(.W(N), .INIT(SEED)) u_state_reg (
        .clk     (clk),
        .reset_n (reset_n),
        .d       (state_d),
        .q       (state_q)
    );

    sll_dual_edge_reg #(.W(N), .INIT(SEED)) u_out_reg (
        .clk     (clk),
        .reset_n (reset_n),
        .d       (out_d),
        .q       (word_out)
    );
endmodule

// File: rtl/sw_limited_lfsr_chk.sv
`timescale 1ns/1ps
module sw_limited_lfsr_chk #(
    parameter int unsigned N     = 16,
    parameter logic [N-1:0] SEED  = 16'h0001,
    parameter int unsigned LIMIT = 7
) (
    input logic         clk,
    input logic         reset_n,
    input logic [N-1:0] word_out,
    input logic [N-1:0] st
);
    localparam int unsigned MAXT = (LIMIT > N - LIMIT - 1) ? LIMIT : (N - LIMIT - 1);

    logic [N-1:0] seen_at_pos;
    logic [N-1:0] seen_at_neg;

    always_ff @(posedge clk or negedge reset_n) begin
        if (!reset_n) seen_at_pos <= SEED;
        else          seen_at_pos <= word_out;
    end

    always_ff @(negedge clk or negedge reset_n) begin
        if (!reset_n) seen_at_neg <= SEED;
        else          seen_at_neg <= word_out;
    end

    assert_seed_in_reset_R1: assert property (@(posedge clk)
        !reset_n |-> word_out == SEED);

    assert_state_nonzero_R4: assert property (@(posedge clk) disable iff (!reset_n)
        st != '0);

    assert_true_or_inv_R5: assert property (@(posedge clk) disable iff (!reset_n)
        (word_out == st) || (word_out == ~st));

    assert_invert_pos_R5: assert property (@(posedge clk) disable iff (!reset_n)
        (word_out != st) |-> ($countones(st ^ seen_at_neg) > LIMIT));

    assert_invert_neg_R5: assert property (@(negedge clk) disable iff (!reset_n)
        (word_out != st) |-> ($countones(st ^ seen_at_pos) > LIMIT));

    assert_pass_pos_R6: assert property (@(posedge clk) disable iff (!reset_n)
        (word_out == st) |-> ($countones(st ^ seen_at_neg) <= LIMIT));

    assert_pass_neg_R6: assert property (@(negedge clk) disable iff (!reset_n)
        (word_out == st) |-> ($countones(st ^ seen_at_pos) <= LIMIT));

    assert_toggle_bound_pos_R7: assert property (@(posedge clk) disable iff (!reset_n)
        $countones(word_out ^ seen_at_neg) <= MAXT);

    assert_toggle_bound_neg_R7: assert property (@(negedge clk) disable iff (!reset_n)
        $countones(word_out ^ seen_at_pos) <= MAXT);
endmodule

bind sw_limited_lfsr sw_limited_lfsr_chk #(.N(N), .SEED(SEED), .LIMIT(LIMIT)) u_chk (
    .clk      (clk),
    .reset_n  (reset_n),
    .word_out (word_out),
    .st       (state_q)
);

// File: tb/sw_limited_lfsr_tb.sv
`timescale 1ns/1ps
module sw_limited_lfsr_tb;
    localparam int PERIOD = 65535;

    logic        clk = 1'b0;
    logic        reset_n = 1'b1;
    logic [15:0] word_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] ref_st;
    logic [15:0] ref_out;
    logic [15:0] prev_dut;
    int          n_inv;
    int          n_pass;

    sw_limited_lfsr u_dut (
        .clk      (clk),
        .reset_n  (reset_n),
        .word_out (word_out)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int pop16(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic model_step();
        logic [15:0] nx;
        nx = {ref_st[14:0], ref_st[15] ^ ref_st[13] ^ ref_st[12] ^ ref_st[10]};
        ref_st = nx;
        if (pop16(nx ^ ref_out) > 7) begin
            ref_out = ~nx;
            n_inv++;
        end else begin
            ref_out = nx;
            n_pass++;
        end
    endtask

    task automatic run_steps(input int steps, input string tag);
        for (int k = 1; k <= steps; k++) begin
            @(posedge clk or negedge clk);
            #1;
            model_step();
            check(word_out == ref_out, tag, word_out, ref_out);
            check(pop16(word_out ^ prev_dut) <= 8, "R7 toggle bound", word_out, prev_dut);
            if (k == PERIOD) begin
                check(ref_st == 16'h0001 && (word_out == 16'h0001 || word_out == 16'hFFFE),
                      "R4 return to seed at step 65535", word_out, ref_out);
            end
            prev_dut = word_out;
        end
    endtask

    task automatic model_reset();
        ref_st   = 16'h0001;
        ref_out  = 16'h0001;
        prev_dut = 16'h0001;
    endtask

    initial begin
        n_inv  = 0;
        n_pass = 0;
        model_reset();
        #1 reset_n = 1'b0;
        #0.5;
        check(word_out == 16'h0001, "R1 seed during reset", word_out, 16'h0001);
        #9.5;
        reset_n = 1'b1;
        #0.5;
        check(word_out == 16'h0001, "R1 seed after release before edge", word_out, 16'h0001);
        run_steps(PERIOD + 3, "R2/R3/R5/R6 full-period step");
        check(n_inv > 0, "R5 inversions seen", 16'(n_inv), 16'd1);
        check(n_pass > 0, "R6 pass-through seen", 16'(n_pass), 16'd1);

        run_steps(37, "R2/R3/R5/R6 pre-reset run");
        #0.5;
        reset_n = 1'b0;
        #0.3;
        check(word_out == 16'h0001, "R8 async reset mid-run", word_out, 16'h0001);
        @(posedge clk);
        #1;
        check(word_out == 16'h0001, "R8 held in reset across edge", word_out, 16'h0001);
        reset_n = 1'b1;
        #0.3;
        check(word_out == 16'h0001, "R8 seed after mid-run release", word_out, 16'h0001);
        model_reset();
        run_steps(64, "R8 restart sequence");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule